// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM read or write burst, one address per clock. A pulse on `start` loads a starting column, a burst-length code and an order bit. The first column appears in the same cycle as the pulse. Each later column appears one clock after the one before it. Every beat is marked valid, and the final beat is marked last.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that size, with the low address bits wrapping. The order is either a modulo count-up from the start, or the start's low bits XOR-ed with the beat index. A full-page burst walks every column of the row, wrapping from the top column back to zero, and keeps going until `term` is seen. Interleaved order is not defined for full-page bursts, so the block falls back to count-up order. A new `start` aborts any burst in progress.

The column stream has no back-pressure. The block emits one beat per clock whenever `beat_vld` is high, and the consumer must take each beat in the cycle it appears. `start`, `term` and the configuration inputs are plain control pins.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after its release with no start, `beat_vld` and `last_beat` are 0.
- R2: In the cycle `start` is high, `beat_vld` is 1 and `col` equals `start_col`. Each following beat appears one clock later.
- R3: With `burst_ilv`=0 and a fixed length, the low log2(N) bits count up modulo N from the start. Example: start 21 with length 8 gives 21,22,23,16,17,18,19,20.
- R4: With `burst_ilv`=1 and a fixed length, the low bits equal the start's low bits XOR the beat index. Example: start 21 with length 8 gives 21,20,23,22,17,16,19,18.
- R5: During a fixed burst, the column bits above the low log2(N) bits never change.
- R6: In a fixed burst of N beats, `last_beat` is 1 only on beat N-1. Unless `start` is high, `beat_vld` is 0 in the next cycle.
- R7: `len_code` encodes the length as 0=1, 1=2, 2=4, 3=8, and 4 to 7 = full page. With length 1 exactly one beat is issued, marked last, and `burst_ilv` has no effect.
- R8: A full-page burst counts up by one each beat across all 10 column bits, wrapping from 1023 to 0. `burst_ilv` is ignored for full-page bursts.
- R9: A full-page burst continues until `term` is high. The beat in that cycle, including the start cycle, is the last one. `term` has no effect on fixed bursts.
- R10: `start` during an active burst abandons it and begins the new sequence in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the configuration on the inputs below |
| start_col | input | 10 | Starting column |
| len_code | input | 3 | Burst length code (0=1, 1=2, 2=4, 3=8, 4-7=full page) |
| burst_ilv | input | 1 | Order: 0 count-up, 1 XOR interleave |
| term | input | 1 | Ends a full-page burst on the current beat |
| col | output | 10 | Column for the current beat |
| beat_vld | output | 1 | Current beat is valid |
| last_beat | output | 1 | Current beat is the final one |

## Verification
The assertions check on every cycle that a start yields a valid beat carrying the start column, and that no beat follows a last beat without a new start. They also check that fixed bursts keep their upper column bits, that full-page bursts step by exactly one, and that length-one starts and terminated full-page beats are marked last. The exact beat orders for each length and order bit, wrap points, the fall-back from interleave to count-up in full-page mode, the ignored terminate in fixed bursts, and aborting a burst by restart can only be shown by the bench's scenarios.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic {
    ORD_UP  = 1'b0,
    ORD_XOR = 1'b1
  } beat_order_e;

  localparam int LEN_CODE_W = 3;
  localparam int FIXED_CODES = 4;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  burst_ilv,
  input  logic                  term,
  output logic [COL_W-1:0]      cur_base,
  output logic [COL_W-1:0]      cur_idx,
  output logic [COL_W-1:0]      cur_mask,
  output beat_order_e           cur_order,
  output logic                  cur_full,
  output logic                  beat_vld,
  output logic                  last_beat
);
  localparam logic [COL_W-1:0] ONE = 1;

  logic             active_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             full_q;
  beat_order_e      order_q;

  logic             dec_full;
  logic [COL_W-1:0] dec_mask;

  always_comb begin
    dec_full = (len_code >= LEN_CODE_W'(FIXED_CODES));
    for (int i = 0; i < COL_W; i++) begin
      dec_mask[i] = dec_full || (i < int'(len_code));
    end
  end

  always_comb begin
    if (start) begin
      cur_base  = start_col;
      cur_idx   = '0;
      cur_mask  = dec_mask;
      cur_full  = dec_full;
      cur_order = (burst_ilv && !dec_full) ? ORD_XOR : ORD_UP;
    end else begin
      cur_base  = base_q;
      cur_idx   = idx_q;
      cur_mask  = mask_q;
      cur_full  = full_q;
      cur_order = order_q;
    end
    beat_vld  = start || active_q;
    last_beat = beat_vld && (cur_full ? term : (cur_idx == cur_mask));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      order_q  <= ORD_UP;
    end else if (beat_vld) begin
      active_q <= !last_beat;
      base_q   <= cur_base;
      idx_q    <= cur_idx + ONE;
      mask_q   <= cur_mask;
      full_q   <= cur_full;
      order_q  <= cur_order;
    end
  end

  p_start_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> beat_vld);

  p_stop_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> (!beat_vld || start));

  p_last_needs_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_vld);
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  beat_order_e      order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low_up, low_xor, low_sel;

  always_comb begin
    low_up  = base + idx;
    low_xor = base ^ idx;
    low_sel = (order == ORD_XOR) ? low_xor : low_up;
    col     = (base & ~mask) | (low_sel & mask);
  end

  always_comb begin
    if (idx == '0) begin
      a_first_is_base_r2: assert (col == base);
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  burst_ilv,
  input  logic                  term,
  output logic [COL_W-1:0]      col,
  output logic                  beat_vld,
  output logic                  last_beat
);
  logic [COL_W-1:0] cur_base, cur_idx, cur_mask;
  beat_order_e      cur_order;
  logic             cur_full;

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .len_code  (len_code),
    .burst_ilv (burst_ilv),
    .term      (term),
    .cur_base  (cur_base),
    .cur_idx   (cur_idx),
    .cur_mask  (cur_mask),
    .cur_order (cur_order),
    .cur_full  (cur_full),
    .beat_vld  (beat_vld),
    .last_beat (last_beat)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base  (cur_base),
    .idx   (cur_idx),
    .mask  (cur_mask),
    .order (cur_order),
    .col   (col)
  );

  p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (col == start_col));

  p_block_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !start && !cur_full && $past(beat_vld && !last_beat))
      |-> (((col ^ $past(col)) & ~cur_mask) == '0));

  p_len1_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_code == '0) |-> (last_beat && col == start_col));

  p_full_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !start && cur_full && $past(beat_vld && !last_beat))
      |-> (col == $past(col) + COL_W'(1)));

  p_term_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && cur_full && term) |-> last_beat);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  localparam logic [9:0] V_ST [NV] = '{10'd21, 10'd21, 10'd509, 10'd509,
                                       10'd1023, 10'd700, 10'd6, 10'd510};
  localparam logic [2:0] V_LC [NV] = '{3'd3, 3'd3, 3'd2, 3'd2,
                                       3'd1, 3'd0, 3'd1, 3'd2};
  localparam logic       V_IL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1,
                                       1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [79:0] V_EXP [NV] = '{
    {10'd21, 10'd22, 10'd23, 10'd16, 10'd17, 10'd18, 10'd19, 10'd20},
    {10'd21, 10'd20, 10'd23, 10'd22, 10'd17, 10'd16, 10'd19, 10'd18},
    {10'd509, 10'd510, 10'd511, 10'd508, 40'd0},
    {10'd509, 10'd508, 10'd511, 10'd510, 40'd0},
    {10'd1023, 10'd1022, 60'd0},
    {10'd700, 70'd0},
    {10'd6, 10'd7, 60'd0},
    {10'd510, 10'd511, 10'd508, 10'd509, 40'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [9:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic burst_ilv = 1'b0;
  logic term = 1'b0;
  logic [9:0] col;
  logic beat_vld, last_beat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .burst_ilv(burst_ilv), .term(term),
    .col(col), .beat_vld(beat_vld), .last_beat(last_beat)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input int sc, input int lc, input bit il);
    @(negedge clk);
    start = 1'b1; start_col = 10'(sc); len_code = 3'(lc); burst_ilv = il;
    #1;
  endtask

  task automatic next_beat();
    @(negedge clk);
    start = 1'b0; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "vld in reset", int'(beat_vld), 0);
    chk("R1", "last in reset", int'(last_beat), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "vld idle", int'(beat_vld), 0);

    for (int i = 0; i < NV; i++) begin
      int n;
      string rq;
      n  = 1 << V_LC[i];
      rq = (V_LC[i] == 0) ? "R7" : (V_IL[i] ? "R4" : "R3");
      launch(int'(V_ST[i]), int'(V_LC[i]), V_IL[i]);
      for (int k = 0; k < n; k++) begin
        if (k > 0) next_beat();
        chk(rq, "col", int'(col), int'(V_EXP[i][79-10*k -: 10]));
        chk("R2", "vld", int'(beat_vld), 1);
        chk("R6", "last", int'(last_beat), (k == n-1) ? 1 : 0);
      end
      next_beat();
      chk("R6", "vld after last", int'(beat_vld), 0);
    end

    // R8: full page, interleave ignored, wraps 1023 -> 0; R9 term ends it
    launch(1022, 7, 1'b1);
    chk("R8", "col b0", int'(col), 1022);
    next_beat(); chk("R8", "col b1", int'(col), 1023);
    next_beat(); chk("R8", "col wrap", int'(col), 0);
    chk("R9", "no last w/o term", int'(last_beat), 0);
    @(negedge clk); start = 1'b0; term = 1'b1; #1;
    chk("R8", "col b3", int'(col), 1);
    chk("R9", "last on term", int'(last_beat), 1);
    @(negedge clk); term = 1'b0; #1;
    chk("R9", "idle after term", int'(beat_vld), 0);

    // R7: code 4 is full page, runs past 8 beats
    launch(40, 4, 1'b0);
    for (int k = 1; k < 10; k++) next_beat();
    chk("R7", "code4 beat9 vld", int'(beat_vld), 1);
    chk("R7", "code4 beat9 col", int'(col), 49);
    @(negedge clk); term = 1'b1; #1;
    chk("R9", "code4 last", int'(last_beat), 1);
    @(negedge clk); term = 1'b0;

    // R9: term on the start cycle of full page
    @(negedge clk); start = 1'b1; start_col = 10'd300; len_code = 3'd7; term = 1'b1; #1;
    chk("R9", "term at start last", int'(last_beat), 1);
    @(negedge clk); start = 1'b0; term = 1'b0; #1;
    chk("R9", "term at start idle", int'(beat_vld), 0);

    // R9: term ignored in fixed burst
    launch(0, 2, 1'b0);
    @(negedge clk); start = 1'b0; term = 1'b1; #1;
    chk("R9", "fixed term not last", int'(last_beat), 0);
    @(negedge clk); term = 1'b0; #1;
    chk("R9", "fixed continues", int'(beat_vld), 1);
    chk("R9", "fixed col", int'(col), 2);
    next_beat();
    chk("R9", "fixed ends b3", int'(last_beat), 1);
    next_beat();

    // R10: restart during burst
    launch(0, 3, 1'b0);
    next_beat(); next_beat();
    chk("R10", "pre-restart col", int'(col), 2);
    launch(100, 1, 1'b0);
    chk("R10", "restart col", int'(col), 100);
    chk("R10", "restart not last", int'(last_beat), 0);
    next_beat();
    chk("R10", "second col", int'(col), 101);
    chk("R10", "second last", int'(last_beat), 1);
    next_beat();
    chk("R10", "idle after", int'(beat_vld), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule